// File: doc/BRIEF.md
# Priority Transmit Mailbox Arbiter

This block decides which of a bank of message mailboxes goes out next on a CAN-style bus. Every mailbox has an enable bit, a direction bit and a 16-bit control word that carries a priority field and a data length field. Software raises a transmit request by writing a mask of ones to the request-set strobe. Among the mailboxes that are enabled, set to transmit and requesting, the arbiter picks the one with the largest priority value. Ties go to the higher mailbox number. The arbiter then offers that mailbox's index and length to a frame serializer over a valid/ready handshake.

Once the serializer accepts an offer, the frame is in progress and arbitration is frozen until the serializer reports completion. A successful completion drops the request and raises the mailbox's acknowledge flag. A failed completion leaves the request pending, so the mailbox competes again. Software can withdraw a request that has not started yet; doing so raises an abort-acknowledge flag. A single interrupt output combines the acknowledge flags through a per-mailbox mask.

Top module: `tx_mbox_arbiter`

## Requirements
- R1: After reset the request, acknowledge and abort flags are all zero, and both tx_valid_o and irq_o are low.
- R2: A mailbox takes part in arbitration only if its request is pending, its enable bit is 1 and its direction bit is 0 (0 = transmit, 1 = receive).
- R3: Among the eligible mailboxes, the one with the largest priority value, taken from control word bits 13:8, is offered on tx_idx_o.
- R4: When eligible mailboxes have equal priority, the highest-numbered one is offered.
- R5: An offer is accepted in a cycle where tx_valid_o and tx_ready_i are both high. From then until tx_done_i, tx_valid_o stays low and the in-progress index is held, so a newer higher-priority request cannot preempt the frame.
- R6: tx_done_i with tx_ok_i=1 clears the mailbox's request and sets its acknowledge bit on the next edge. With tx_ok_i=0 the request stays pending and the mailbox is offered again.
- R7: A 1 in a bit of req_set_i raises that mailbox's request on the next edge. A 0 bit has no effect.
- R8: A 1 in a bit of ack_clr_i clears that acknowledge bit. A success reported for the same mailbox in the same cycle takes precedence and leaves the bit set.
- R9: A 1 in a bit of req_rst_i cancels a pending request that has not been accepted and sets that mailbox's abort bit. For the in-progress mailbox it is ignored. A 1 in abort_clr_i clears an abort bit.
- R10: irq_o is high whenever any acknowledge bit is set and its bit in mbx_irq_mask_i is 1.
- R11: tx_len_o gives bits 3:0 of the control word of the mailbox on tx_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mbx_en_i | input | 32 | Per-mailbox enable |
| mbx_dir_i | input | 32 | Per-mailbox direction, 0 = transmit |
| mbx_ctrl_i | input | 512 | Control words, 16 bits per mailbox, mailbox k at bits 16k+15:16k |
| mbx_irq_mask_i | input | 32 | Per-mailbox acknowledge interrupt mask |
| req_set_i | input | 32 | Write-1-to-set request strobe |
| req_rst_i | input | 32 | Write-1 request cancel strobe |
| ack_clr_i | input | 32 | Write-1-to-clear acknowledge strobe |
| abort_clr_i | input | 32 | Write-1-to-clear abort strobe |
| tx_valid_o | output | 1 | Offer to the serializer is valid |
| tx_ready_i | input | 1 | Serializer accepts the offer |
| tx_idx_o | output | 5 | Offered or in-progress mailbox index |
| tx_len_o | output | 4 | Data length of the mailbox on tx_idx_o |
| tx_done_i | input | 1 | Frame finished, one-cycle pulse |
| tx_ok_i | input | 1 | Frame finished successfully, qualified by tx_done_i |
| req_o | output | 32 | Pending request flags |
| ack_o | output | 32 | Acknowledge flags |
| abort_o | output | 32 | Abort-acknowledge flags |
| irq_o | output | 1 | Global mailbox interrupt |

## Verification
The assertions assume that the serializer asserts tx_done_i only while a frame is in progress, and that tx_ready_i and tx_done_i are single-cycle pulses. One of the assertions checks the first of these at the input. The bench changes every input on the falling clock edge, one scenario task at a time. It raises ready only after it has seen an offer and raises done only after an accepted offer, and it never pulses a strobe without then returning it to zero. Configuration inputs (enable, direction, control words, mask) change only while no request is pending for the mailbox being changed.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_e;

  localparam int unsigned CTRL_W_DEF  = 16;
  localparam int unsigned PRIO_LSB    = 8;
  localparam int unsigned LEN_LSB     = 0;
endpackage

// File: rtl/tx_arb_select.sv
module tx_arb_select #(
  parameter int unsigned NUM    = 32,
  parameter int unsigned PRIO_W = 6,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]        elig_i,
  input  logic [NUM*PRIO_W-1:0] prio_i,
  output logic                  valid_o,
  output logic [IDX_W-1:0]      idx_o
);
  // heap-ordered comparison tree; key {prio, idx} breaks ties to the higher index
  localparam int unsigned NODES = 2*NUM - 1;

  logic [NODES-1:0] nv;
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar k = 0; k < NUM; k++) begin : g_leaf
    assign nv[NUM-1+k] = elig_i[k];
    assign np[NUM-1+k] = prio_i[k*PRIO_W +: PRIO_W];
    assign ni[NUM-1+k] = IDX_W'(k);
  end

  for (genvar n = 0; n < NUM-1; n++) begin : g_node
    logic pick_r;
    assign pick_r = nv[2*n+2] &&
                    (!nv[2*n+1] || ({np[2*n+2], ni[2*n+2]} > {np[2*n+1], ni[2*n+1]}));
    assign nv[n] = nv[2*n+1] | nv[2*n+2];
    assign np[n] = pick_r ? np[2*n+2] : np[2*n+1];
    assign ni[n] = pick_r ? ni[2*n+2] : ni[2*n+1];
  end

  assign valid_o = nv[0];
  assign idx_o   = ni[0];
endmodule

// File: rtl/tx_arb_flags.sv
module tx_arb_flags #(
  parameter int unsigned NUM = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] cancel_i,
  input  logic [NUM-1:0] ack_clr_i,
  input  logic [NUM-1:0] abort_clr_i,
  input  logic [NUM-1:0] lock_i,
  input  logic [NUM-1:0] done_ok_i,
  input  logic [NUM-1:0] mask_i,
  output logic [NUM-1:0] req_o,
  output logic [NUM-1:0] ack_o,
  output logic [NUM-1:0] abort_o,
  output logic           irq_o
);
  logic [NUM-1:0] req_q, ack_q, abort_q;
  logic [NUM-1:0] cancel_eff;

  // a mailbox already handed to the serializer cannot be cancelled
  assign cancel_eff = cancel_i & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      ack_q   <= '0;
      abort_q <= '0;
    end else begin
      req_q   <= (req_q & ~cancel_eff & ~done_ok_i) | set_i;
      ack_q   <= (ack_q & ~ack_clr_i) | done_ok_i;
      abort_q <= (abort_q & ~abort_clr_i) | (cancel_eff & req_q);
    end
  end

  assign req_o   = req_q;
  assign ack_o   = ack_q;
  assign abort_o = abort_q;
  assign irq_o   = |(ack_q & mask_i);

  for (genvar k = 0; k < NUM; k++) begin : g_chk
    p_set_raises_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> req_o[k]);
    p_zero_no_effect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && !req_o[k]) |=> !req_o[k]);
    p_cancel_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cancel_i[k] && !lock_i[k] && req_o[k] && !set_i[k]) |=> (abort_o[k] && !req_o[k]));
    p_cancel_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i[k] && req_o[k] && !done_ok_i[k]) |=> req_o[k]);
    p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_clr_i[k] && !done_ok_i[k]) |=> !ack_o[k]);
  end
endmodule

// File: rtl/tx_arb_ctrl.sv
module tx_arb_ctrl
  import tx_arb_pkg::*;
#(
  parameter int unsigned NUM = 32,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             tx_ready_i,
  input  logic             tx_done_i,
  input  logic             tx_ok_i,
  output logic             tx_valid_o,
  output logic [IDX_W-1:0] tx_idx_o,
  output logic [NUM-1:0]   lock_o,
  output logic [NUM-1:0]   done_ok_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] busy_idx_o
);
  arb_state_e       state_q;
  logic [IDX_W-1:0] busy_idx_q;
  logic             fire;

  assign tx_valid_o = (state_q == ST_IDLE) && win_valid_i;
  assign fire       = tx_valid_o && tx_ready_i;
  assign tx_idx_o   = (state_q == ST_BUSY) ? busy_idx_q : win_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      busy_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire) begin
          state_q    <= ST_BUSY;
          busy_idx_q <= win_idx_i;
        end
        ST_BUSY: if (tx_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lock_o    = '0;
    done_ok_o = '0;
    if (state_q == ST_BUSY) begin
      lock_o[busy_idx_q] = 1'b1;
      if (tx_done_i && tx_ok_i) done_ok_o[busy_idx_q] = 1'b1;
    end else if (fire) begin
      lock_o[win_idx_i] = 1'b1;
    end
  end

  assign busy_o     = (state_q == ST_BUSY);
  assign busy_idx_o = busy_idx_q;

  p_no_offer_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (!tx_valid_o && tx_idx_o == $past(win_idx_i)));
  p_hold_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tx_done_i) |=> (busy_o && $stable(tx_idx_o)));
  p_done_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |-> busy_o);
endmodule

// File: rtl/tx_mbox_arbiter.sv
module tx_mbox_arbiter
  import tx_arb_pkg::*;
#(
  parameter int unsigned NUM    = 32,
  parameter int unsigned CTRL_W = CTRL_W_DEF,
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned LEN_W  = 4,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM-1:0]        mbx_en_i,
  input  logic [NUM-1:0]        mbx_dir_i,
  input  logic [NUM*CTRL_W-1:0] mbx_ctrl_i,
  input  logic [NUM-1:0]        mbx_irq_mask_i,
  input  logic [NUM-1:0]        req_set_i,
  input  logic [NUM-1:0]        req_rst_i,
  input  logic [NUM-1:0]        ack_clr_i,
  input  logic [NUM-1:0]        abort_clr_i,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic [IDX_W-1:0]      tx_idx_o,
  output logic [LEN_W-1:0]      tx_len_o,
  input  logic                  tx_done_i,
  input  logic                  tx_ok_i,
  output logic [NUM-1:0]        req_o,
  output logic [NUM-1:0]        ack_o,
  output logic [NUM-1:0]        abort_o,
  output logic                  irq_o
);
  logic [NUM*PRIO_W-1:0] prio_flat;
  logic [LEN_W-1:0]      len_arr [NUM];
  logic [NUM-1:0]        elig, lock, done_ok;
  logic                  win_valid, busy;
  logic [IDX_W-1:0]      win_idx, busy_idx;

  for (genvar k = 0; k < NUM; k++) begin : g_fields
    assign prio_flat[k*PRIO_W +: PRIO_W] = mbx_ctrl_i[k*CTRL_W + PRIO_LSB +: PRIO_W];
    assign len_arr[k]                    = mbx_ctrl_i[k*CTRL_W + LEN_LSB +: LEN_W];
  end

  assign elig     = req_o & mbx_en_i & ~mbx_dir_i;
  assign tx_len_o = len_arr[tx_idx_o];

  tx_arb_select #(.NUM(NUM), .PRIO_W(PRIO_W)) u_select (
    .elig_i  (elig),
    .prio_i  (prio_flat),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  tx_arb_ctrl #(.NUM(NUM)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .tx_ready_i  (tx_ready_i),
    .tx_done_i   (tx_done_i),
    .tx_ok_i     (tx_ok_i),
    .tx_valid_o  (tx_valid_o),
    .tx_idx_o    (tx_idx_o),
    .lock_o      (lock),
    .done_ok_o   (done_ok),
    .busy_o      (busy),
    .busy_idx_o  (busy_idx)
  );

  tx_arb_flags #(.NUM(NUM)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (req_set_i),
    .cancel_i    (req_rst_i),
    .ack_clr_i   (ack_clr_i),
    .abort_clr_i (abort_clr_i),
    .lock_i      (lock),
    .done_ok_i   (done_ok),
    .mask_i      (mbx_irq_mask_i),
    .req_o       (req_o),
    .ack_o       (ack_o),
    .abort_o     (abort_o),
    .irq_o       (irq_o)
  );

  // independent linear scan used only by the checks below
  logic higher_exists, tie_above;
  always_comb begin
    higher_exists = 1'b0;
    tie_above     = 1'b0;
    for (int j = 0; j < NUM; j++) begin
      if (elig[j] && prio_flat[j*PRIO_W +: PRIO_W] > prio_flat[win_idx*PRIO_W +: PRIO_W])
        higher_exists = 1'b1;
      if (elig[j] && prio_flat[j*PRIO_W +: PRIO_W] == prio_flat[win_idx*PRIO_W +: PRIO_W]
          && j > int'(win_idx))
        tie_above = 1'b1;
    end
  end

  p_valid_elig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (req_o[tx_idx_o] && mbx_en_i[tx_idx_o] && !mbx_dir_i[tx_idx_o]));
  p_winner_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !higher_exists);
  p_tie_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !tie_above);
  p_ack_after_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_done_i && tx_ok_i) |=> ack_o[$past(busy_idx)]);
  p_retry_keeps_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_done_i && !tx_ok_i) |=> req_o[$past(busy_idx)]);
  p_irq_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ack_o != '0));
endmodule

// File: tb/tb_tx_mbox_arbiter.sv
module tb_tx_mbox_arbiter;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    en, dir, mask, rset, rrst, aclr, bclr;
  logic [N*16-1:0] ctrl;
  logic            ready, done, ok;
  logic            valid, irq;
  logic [4:0]      idx;
  logic [3:0]      len;
  logic [N-1:0]    req, ack, abrt;

  int n_chk = 0;
  int n_fail = 0;

  tx_mbox_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mbx_en_i(en), .mbx_dir_i(dir), .mbx_ctrl_i(ctrl), .mbx_irq_mask_i(mask),
    .req_set_i(rset), .req_rst_i(rrst), .ack_clr_i(aclr), .abort_clr_i(bclr),
    .tx_valid_o(valid), .tx_ready_i(ready), .tx_idx_o(idx), .tx_len_o(len),
    .tx_done_i(done), .tx_ok_i(ok),
    .req_o(req), .ack_o(ack), .abort_o(abrt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input int k, input int prio, input int ln);
    ctrl[k*16 +: 16] = {2'b00, 6'(prio), 4'b0000, 4'(ln)};
  endtask

  task automatic wr(input logic [N-1:0] s, input logic [N-1:0] r,
                    input logic [N-1:0] ac, input logic [N-1:0] bc);
    @(negedge clk);
    rset = s; rrst = r; aclr = ac; bclr = bc;
    @(negedge clk);
    rset = '0; rrst = '0; aclr = '0; bclr = '0;
  endtask

  task automatic accept();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic finish_frame(input logic good, input logic [N-1:0] ac);
    @(negedge clk); done = 1'b1; ok = good; aclr = ac;
    @(negedge clk); done = 1'b0; ok = 1'b0; aclr = '0;
  endtask

  task automatic cleanup();
    wr('0, '1, '1, '1);
    wr('0, '0, '0, '1);
    en = '1; dir = '0; mask = '0; ctrl = '0;
  endtask

  task automatic t_reset();
    chk("R1 req", req, 0);
    chk("R1 ack", ack, 0);
    chk("R1 abort", abrt, 0);
    chk("R1 valid", valid, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_write_zero();
    wr(32'h0000_0000, '0, '0, '0);
    chk("R7 zero write no req", req, 0);
    chk("R7 zero write no valid", valid, 0);
    wr(32'h0000_0100, '0, '0, '0);
    chk("R7 set raises", req, 32'h0000_0100);
    wr(32'h0000_0000, '0, '0, '0);
    chk("R7 zero keeps", req, 32'h0000_0100);
    cleanup();
  endtask

  task automatic t_elig();
    dir[10] = 1'b1; en[11] = 1'b0;
    wr(32'h0000_0C00, '0, '0, '0);
    chk("R2 req pending", req, 32'h0000_0C00);
    chk("R2 ineligible no offer", valid, 0);
    wr(32'h0000_0004, '0, '0, '0);
    chk("R2 valid eligible", valid, 1);
    chk("R2 idx eligible", idx, 2);
    cleanup();
  endtask

  task automatic t_prio_len();
    set_ctrl(20, 2, 3); set_ctrl(4, 40, 9);
    wr(32'h0010_0010, '0, '0, '0);
    chk("R3 valid", valid, 1);
    chk("R3 largest prio", idx, 4);
    chk("R11 length", len, 9);
    cleanup();
  endtask

  task automatic t_tie();
    set_ctrl(3, 5, 0); set_ctrl(9, 5, 0); set_ctrl(30, 4, 0);
    wr(32'h4000_0208, '0, '0, '0);
    chk("R4 tie high idx", idx, 9);
    cleanup();
    wr(32'h8000_0001, '0, '0, '0);
    chk("R4 zero prio tie", idx, 31);
    cleanup();
  endtask

  task automatic t_no_preempt();
    set_ctrl(4, 40, 1); set_ctrl(20, 2, 2); set_ctrl(7, 63, 5);
    wr(32'h0010_0010, '0, '0, '0);
    accept();
    chk("R5 valid low busy", valid, 0);
    chk("R5 idx held", idx, 4);
    wr(32'h0000_0080, '0, '0, '0);
    chk("R5 no preempt valid", valid, 0);
    chk("R5 no preempt idx", idx, 4);
    finish_frame(1'b1, '0);
    chk("R6 ack set", ack, 32'h0000_0010);
    chk("R6 req cleared", req, 32'h0010_0080);
    chk("R5 next winner", idx, 7);
    chk("R5 next valid", valid, 1);
    chk("R11 next len", len, 5);
    accept(); finish_frame(1'b1, '0);
    accept(); finish_frame(1'b1, '0);
    chk("R6 all acked", ack, 32'h0010_0090);
    chk("R6 none pending", valid, 0);
    wr('0, '0, '1, '0);
    chk("R8 ack cleared", ack, 0);
    cleanup();
  endtask

  task automatic t_retry();
    wr(32'h0000_0020, '0, '0, '0);
    accept();
    finish_frame(1'b0, '0);
    chk("R6 fail keeps req", req, 32'h0000_0020);
    chk("R6 fail no ack", ack, 0);
    chk("R6 reoffered", valid, 1);
    chk("R6 reoffered idx", idx, 5);
    accept();
    finish_frame(1'b1, 32'h0000_0020);
    chk("R8 set beats clear", ack, 32'h0000_0020);
    cleanup();
  endtask

  task automatic t_abort();
    wr(32'h0000_0020, '0, '0, '0);
    wr('0, 32'h0000_0020, '0, '0);
    chk("R9 cancel req", req, 0);
    chk("R9 abort set", abrt, 32'h0000_0020);
    chk("R9 no offer", valid, 0);
    wr('0, 32'h0000_0040, '0, '0);
    chk("R9 cancel idle no abort", abrt, 32'h0000_0020);
    wr('0, '0, '0, 32'h0000_0020);
    chk("R9 abort cleared", abrt, 0);
    wr(32'h0000_0800, '0, '0, '0);
    accept();
    wr('0, 32'h0000_0800, '0, '0);
    chk("R9 busy ignored req", req, 32'h0000_0800);
    chk("R9 busy no abort", abrt, 0);
    finish_frame(1'b1, '0);
    chk("R9 busy completes", ack, 32'h0000_0800);
    cleanup();
  endtask

  task automatic t_irq();
    wr(32'h0000_2000, '0, '0, '0);
    accept(); finish_frame(1'b1, '0);
    chk("R10 masked off", irq, 0);
    mask[13] = 1'b1; #1;
    chk("R10 irq high", irq, 1);
    mask[13] = 1'b0; mask[12] = 1'b1; #1;
    chk("R10 other mask", irq, 0);
    mask[13] = 1'b1;
    wr('0, '0, 32'h0000_2000, '0);
    chk("R10 irq after clear", irq, 0);
    cleanup();
  endtask

  initial begin
    en = '1; dir = '0; mask = '0; ctrl = '0;
    rset = '0; rrst = '0; aclr = '0; bclr = '0;
    ready = 1'b0; done = 1'b0; ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_zero();
    t_elig();
    t_prio_len();
    t_tie();
    t_no_preempt();
    t_retry();
    t_abort();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule